// File: doc/BRIEF.md
# Time-Multiplexed Dual-Port RAM Wrapper

This block gives a system one read port and one write port that both work in every port cycle, although underneath there is only a single-port synchronous array. The array is clocked at twice the port rate. A phase toggle splits every port cycle into two fast-clock slots: the first serves the read port, the second serves the write port. An address multiplexer steers the right port's address to the array in each slot. Write data is driven onto the array's data input only in the write slot, and only when a write is requested. The read result is captured into an output register, so it stays valid for a whole port cycle.

The block is clocked by the fast clock only. The `port_start` output is high during the read slot, which marks the first half of each port cycle. Port inputs are applied at the start of a port cycle and held for both of its slots. The system never reads and writes the same address in the same port cycle, so the block contains no collision arbitration. No port ever stalls.

Top module: `tdmr_wrapper`

## Requirements
- R1: While `rst` is high at a rising edge, the slot toggle returns to the read slot and `rd_data` clears to zero. In the first cycle after reset, `port_start` is 1 and `rd_data` is 0.
- R2: After reset, `port_start` inverts on every rising edge of `clk`. Value 1 means the read slot and value 0 means the write slot, so one port cycle spans two fast clocks.
- R3: At the rising edge that ends a read slot, `rd_data` takes the array word at `rd_addr`. It then holds that value across the next edge, which ends the write slot. It is therefore stable for two fast clocks.
- R4: When `wr_en` is 1 in a port cycle, `wr_data` is stored at `wr_addr` at the edge that ends the write slot. A read of that address in any later port cycle returns the new word.
- R5: When `wr_en` is 0 in a port cycle, no word of the array changes.
- R6: During the read slot, the array sees no write request and the write data path is released, with zero driven onto it.
- R7: A read and a write to different addresses in the same port cycle both complete. The read returns the contents from before the cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the port rate |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | ADDR_W | Read port address, held for the port cycle |
| wr_en | input | 1 | Write request for this port cycle |
| wr_addr | input | ADDR_W | Write port address, held for the port cycle |
| wr_data | input | DATA_W | Write port data, held for the port cycle |
| rd_data | output | DATA_W | Captured read word |
| port_start | output | 1 | High in the read slot, the first half of a port cycle |

## Verification
The read result is due one fast edge after a port cycle starts, which is the edge that ends the read slot. It must still hold after the second edge. A write becomes visible to a read issued in the next port cycle. The bench drives each port cycle on a falling edge in the read slot. It compares `rd_data` and `port_start` with its own behavioural model at the falling edge after each of the two rising edges. Its model memory is updated only after the read of that cycle has been taken.

// File: rtl/tdmr_pkg.sv
package tdmr_pkg;

    typedef enum logic {
        SLOT_RD = 1'b0,
        SLOT_WR = 1'b1
    } slot_e;

    function automatic slot_e slot_after(input slot_e s);
        return (s == SLOT_RD) ? SLOT_WR : SLOT_RD;
    endfunction

    function automatic logic slot_is_read(input slot_e s);
        return s == SLOT_RD;
    endfunction

endpackage

// File: rtl/tdmr_slot_seq.sv
module tdmr_slot_seq
    import tdmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_e slot
);

    slot_e slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= SLOT_RD;
        end else begin
            slot_q <= slot_after(slot_q);
        end
    end

    assign slot = slot_q;

endmodule

// File: rtl/tdmr_port_mux.sv
module tdmr_port_mux
    import tdmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_e             slot,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata
);

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } ram_req_t;

    ram_req_t req;
    logic     drive_en;

    always_comb begin
        drive_en  = (slot == SLOT_WR) && wr_en;
        req.we    = drive_en;
        req.addr  = slot_is_read(slot) ? rd_addr : wr_addr;
        req.wdata = drive_en ? wr_data : '0;
    end

    assign ram_addr  = req.addr;
    assign ram_we    = req.we;
    assign ram_wdata = req.wdata;

    // R6: read slot carries no write and a released data path
    a_r6_read_slot_quiet: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_RD) |-> (!ram_we && ram_wdata == '0));

endmodule

// File: rtl/tdmr_sp_array.sv
module tdmr_sp_array #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    // checker state for R4: remember the last write and look at it one edge later
    logic              chk_vld;
    logic [ADDR_W-1:0] chk_addr;
    logic [DATA_W-1:0] chk_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_vld <= 1'b0;
        end else begin
            chk_vld  <= we;
            chk_addr <= addr;
            chk_data <= wdata;
            if (chk_vld) begin
                a_r4_write_lands: assert (mem[chk_addr] == chk_data)
                    else $error("a_r4_write_lands: stored word mismatch");
            end
        end
    end

endmodule

// File: rtl/tdmr_rd_capture.sv
module tdmr_rd_capture
    import tdmr_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_e             slot,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else if (slot_is_read(slot)) begin
            q_r <= d_in;
        end
    end

    assign q = q_r;

endmodule

// File: rtl/tdmr_wrapper.sv
module tdmr_wrapper
    import tdmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              port_start
);

    slot_e             slot;
    logic [ADDR_W-1:0] ram_addr;
    logic              ram_we;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] ram_rdata;

    tdmr_slot_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    tdmr_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .ram_wdata (ram_wdata)
    );

    tdmr_sp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst   (rst),
        .addr  (ram_addr),
        .we    (ram_we),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    tdmr_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk  (clk),
        .rst  (rst),
        .slot (slot),
        .d_in (ram_rdata),
        .q    (rd_data)
    );

    assign port_start = slot_is_read(slot);

    // R1: first cycle after reset is a read slot with cleared output
    logic rst_seen;
    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst_seen && !rst) begin
            a_r1_reset_state: assert (port_start && rd_data == '0)
                else $error("a_r1_reset_state: bad state after reset");
        end
    end

    // R2: slots alternate every fast clock
    a_r2_slot_alternates: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (port_start != $past(port_start)));

    // R3: output holds across the edge that ends the write slot
    a_r3_read_held: assert property (@(posedge clk) disable iff (rst)
        !port_start |=> $stable(rd_data));

endmodule

// File: tb/test_tdmr_wrapper.sv
`timescale 1ns/1ps
module test_tdmr_wrapper;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          port_start;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    logic done = 1'b0;

    logic [DW-1:0] model [NW];
    bit            known [NW];
    logic [15:0]   lfsr = 16'hACE1;

    always #10 clk = ~clk;

    tdmr_wrapper #(.ADDR_W(AW), .DATA_W(DW)) i_tdmr_wrapper (
        .clk        (clk),
        .rst        (rst),
        .rd_addr    (rd_addr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .port_start (port_start)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a falling edge inside a read slot; returns at the falling edge of the next read slot.
    task automatic port_cycle(input logic [AW-1:0] ra, input logic we,
                              input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                              input string req);
        logic [DW-1:0] exp_rd;
        bit            exp_known;
        rd_addr = ra;
        wr_en   = we;
        wr_addr = wa;
        wr_data = wd;
        exp_rd    = model[ra];
        exp_known = known[ra];
        @(negedge clk);
        chk("R2 write slot", {15'd0, port_start}, 16'd0);
        if (exp_known) chk({req, " R3 read captured"}, rd_data, exp_rd);
        @(negedge clk);
        chk("R2 read slot", {15'd0, port_start}, 16'd1);
        if (exp_known) chk({req, " R3 read held"}, rd_data, exp_rd);
        if (we) begin
            model[wa] = wd;
            known[wa] = 1'b1;
        end
    endtask

    initial begin
        for (int i = 0; i < NW; i++) known[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 port_start after reset", {15'd0, port_start}, 16'd1);
        chk("R1 rd_data after reset", rd_data, 16'd0);

        // R4: fill every word
        for (int i = 0; i < NW; i++) begin
            port_cycle(AW'(0), 1'b1, AW'(i), DW'(16'h1000 + i * 16'h0101), "R4 fill");
        end
        // R4: read back all words
        for (int i = 0; i < NW; i++) begin
            port_cycle(AW'(i), 1'b0, AW'(0), 16'h0000, "R4 readback");
        end

        // R5: write enable low with different data leaves word unchanged
        port_cycle(AW'(5), 1'b0, AW'(9), 16'hDEAD, "R5 masked write");
        port_cycle(AW'(9), 1'b0, AW'(9), 16'hBEEF, "R5 word 9 unchanged");
        port_cycle(AW'(9), 1'b0, AW'(1), 16'h0000, "R5 word 9 still unchanged");

        // R7: concurrent read and write to different addresses
        port_cycle(AW'(3), 1'b1, AW'(4), 16'h5A5A, "R7 concurrent");
        port_cycle(AW'(4), 1'b1, AW'(3), 16'hA5A5, "R7 new word 4 visible");
        port_cycle(AW'(3), 1'b0, AW'(0), 16'h0000, "R7 new word 3 visible");
        // boundary addresses
        port_cycle(AW'(NW-1), 1'b1, AW'(0), 16'hFFFF, "R7 top and bottom");
        port_cycle(AW'(0), 1'b1, AW'(NW-1), 16'h0001, "R4 bottom word");
        port_cycle(AW'(NW-1), 1'b0, AW'(0), 16'h0000, "R4 top word");

        // mixed pseudo-random traffic
        for (int n = 0; n < 300; n++) begin
            logic [AW-1:0] ra;
            logic [AW-1:0] wa;
            logic          we;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ra = lfsr[AW-1:0];
            wa = lfsr[AW+5:6];
            if (wa == ra) wa = wa ^ AW'(1);
            we = lfsr[15] | lfsr[2];
            port_cycle(ra, we, wa, lfsr ^ 16'h3C3C, we ? "R4 R7 random" : "R5 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule